// File: doc/BRIEF.md
# Ordered Event Frame Sequencer

This block merges frames arriving on several AXI4-Stream slave ports into one AXI4-Stream master stream. Every event contributes one frame from each enabled source port, and the frames of an event always leave in ascending port order. Each event therefore leaves as a series of separate frames whose order a receiver can rely on, never as one merged super-frame.

In front of every forwarded frame the block emits a single header beat. The header carries the sideband information a receiver needs to rebuild the source stream: destination, first-beat user bits, the source port, the low byte of an event counter and a flag that marks the final frame of the event. Nothing is appended after a payload. Payload beats keep their data, byte enables and end marker, and the sideband outputs stay at zero because the header already carries that information.

An enable mask selects which ports take part. The mask is read live while the block waits for the first frame of an event. It is captured when that frame's header leaves, and it holds until the event ends.

Top module: `fseq_merge`

## Requirements
- R1: While reset is high and in the first cycle after it, m_tvalid is 0 and every s_tready bit is 0. The first header after reset carries event count 0.
- R2: A header beat has m_tkeep all ones and m_tlast 0. TDEST sits at bit 0 upward, the user bits at bit 8 upward, the port index at bits [23:16] and the event count low byte at bits [31:24]. The last-frame flag is at bit 32. Every other bit is 0. TDEST and TUSER are taken from the first beat of the frame, and later beats' values have no effect.
- R3: Within an event, each enabled port sends exactly one frame, in ascending index order. Disabled ports are skipped and never see s_tready.
- R4: The block waits for the currently selected port. A frame that is ready on another port receives no s_tready and produces no output until its turn comes.
- R5: Payload beats leave with TDATA, TKEEP and TLAST unchanged and in order. m_tdest and m_tuser are 0 on every beat.
- R6: The header is the only added beat. The beat after a payload beat with TLAST is the next frame's header, and no tail beat is ever produced.
- R7: The event counter is 8 bits wide. It advances by one after the TLAST of the last enabled port's frame, and it wraps from 255 to 0.
- R8: The header's last-frame flag is 1 only for the frame of the highest enabled port of the event.
- R9: While m_tvalid is 1 and m_tready is 0, the output beat stays unchanged. No beat is lost or duplicated under backpressure.
- R10: The mask is read until an event's first header leaves, and it is then held for the rest of the event. A change made mid-event affects only the next event. An all-zero mask produces no output and no s_tready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_mask | input | NUM_PORTS | Port enable mask |
| s_tvalid | input | NUM_PORTS | Per-port valid |
| s_tready | output | NUM_PORTS | Per-port ready |
| s_tdata | input | NUM_PORTS*DATA_W | Per-port data, port p at slice p |
| s_tkeep | input | NUM_PORTS*KEEP_W | Per-port byte enables |
| s_tlast | input | NUM_PORTS | Per-port end of frame |
| s_tdest | input | NUM_PORTS*DEST_W | Per-port destination |
| s_tuser | input | NUM_PORTS*USER_W | Per-port user bits |
| m_tvalid | output | 1 | Output valid |
| m_tready | input | 1 | Output ready |
| m_tdata | output | DATA_W | Output data (header or payload) |
| m_tkeep | output | KEEP_W | Output byte enables |
| m_tlast | output | 1 | Output end of frame |
| m_tdest | output | DEST_W | Output destination, always 0 |
| m_tuser | output | USER_W | Output user bits, always 0 |

## Verification
A header appears on the output one cycle after the edge at which the selected port presents valid data and the output register is free. A payload beat appears one cycle after its input handshake. Under backpressure both wait further while m_tready is low. Each cycle the bench drives its inputs after the falling edge and lets them settle. It then evaluates the handshakes that the next rising edge will complete and compares any accepted output beat against a scoreboard of expected beats in strict order. The waiting cases (a gated selected port, or a zero mask) are checked as an unchanged output-beat count and an all-zero s_tready over a span of cycles.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  typedef enum logic [1:0] {
    ST_FIRST = 2'd0,
    ST_HDR   = 2'd1,
    ST_PAY   = 2'd2
  } seq_st_t;

  localparam int HDR_DEST_LSB = 0;
  localparam int HDR_USER_LSB = 8;
  localparam int HDR_PORT_LSB = 16;
  localparam int HDR_EVT_LSB  = 24;
  localparam int HDR_LAST_BIT = 32;
  localparam int EVT_W        = 8;
endpackage

// File: rtl/fseq_port_pick.sv
module fseq_port_pick #(
  parameter int NUM_PORTS = 3,
  parameter int IDX_W     = 2
) (
  input  logic [NUM_PORTS-1:0] mask,
  input  logic [IDX_W-1:0]     cur,
  output logic [IDX_W-1:0]     first,
  output logic                 first_last,
  output logic [IDX_W-1:0]     nxt,
  output logic                 cur_last
);
  // lowest enabled port, and lowest enabled port above cur
  always_comb begin
    first = '0;
    nxt   = cur;
    for (int i = NUM_PORTS - 1; i >= 0; i--) begin
      if (mask[i]) first = IDX_W'(i);
      if (mask[i] && (IDX_W'(i) > cur)) nxt = IDX_W'(i);
    end
  end

  // a port is last when no enabled port sits above it
  always_comb begin
    first_last = 1'b1;
    cur_last   = 1'b1;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (mask[i] && (IDX_W'(i) > first)) first_last = 1'b0;
      if (mask[i] && (IDX_W'(i) > cur))   cur_last   = 1'b0;
    end
  end
endmodule

// File: rtl/fseq_hdr_build.sv
module fseq_hdr_build
  import fseq_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEST_W = 4,
  parameter int USER_W = 3,
  parameter int IDX_W  = 2
) (
  input  logic [DEST_W-1:0] dest,
  input  logic [USER_W-1:0] user,
  input  logic [IDX_W-1:0]  port,
  input  logic [EVT_W-1:0]  evt,
  input  logic              last_flag,
  output logic [DATA_W-1:0] hdr
);
  always_comb begin
    hdr                          = '0;
    hdr[HDR_DEST_LSB +: DEST_W]  = dest;
    hdr[HDR_USER_LSB +: USER_W]  = user;
    hdr[HDR_PORT_LSB +: IDX_W]   = port;
    hdr[HDR_EVT_LSB  +: EVT_W]   = evt;
    hdr[HDR_LAST_BIT]            = last_flag;
  end
endmodule

// File: rtl/fseq_out_reg.sv
module fseq_out_reg #(
  parameter int DATA_W = 64,
  parameter int KEEP_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d_data,
  input  logic [KEEP_W-1:0] d_keep,
  input  logic              d_last,
  output logic              free,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic [KEEP_W-1:0] m_tkeep,
  output logic              m_tlast
);
  assign free = !m_tvalid || m_tready;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_tvalid <= 1'b0;
    end else if (load) begin
      m_tvalid <= 1'b1;
    end else if (m_tready) begin
      m_tvalid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      m_tdata <= d_data;
      m_tkeep <= d_keep;
      m_tlast <= d_last;
    end
  end

  // R9: a stalled beat stays put
  assert_hold_stalled_R9: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tkeep) && $stable(m_tlast)));

  // R9: the sequencer never overwrites a beat still waiting
  assert_no_overrun_R9: assert property (@(posedge clk) disable iff (rst)
    load |-> (!m_tvalid || m_tready));
endmodule

// File: rtl/fseq_merge.sv
module fseq_merge
  import fseq_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int DATA_W    = 64,
  parameter int KEEP_W    = DATA_W / 8,
  parameter int DEST_W    = 4,
  parameter int USER_W    = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_PORTS-1:0]          en_mask,
  input  logic [NUM_PORTS-1:0]          s_tvalid,
  output logic [NUM_PORTS-1:0]          s_tready,
  input  logic [NUM_PORTS*DATA_W-1:0]   s_tdata,
  input  logic [NUM_PORTS*KEEP_W-1:0]   s_tkeep,
  input  logic [NUM_PORTS-1:0]          s_tlast,
  input  logic [NUM_PORTS*DEST_W-1:0]   s_tdest,
  input  logic [NUM_PORTS*USER_W-1:0]   s_tuser,
  output logic                          m_tvalid,
  input  logic                          m_tready,
  output logic [DATA_W-1:0]             m_tdata,
  output logic [KEEP_W-1:0]             m_tkeep,
  output logic                          m_tlast,
  output logic [DEST_W-1:0]             m_tdest,
  output logic [USER_W-1:0]             m_tuser
);
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  seq_st_t              state;
  logic [IDX_W-1:0]     sel;
  logic [NUM_PORTS-1:0] ev_mask;
  logic [EVT_W-1:0]     evt_cnt;

  logic [NUM_PORTS-1:0] pick_mask;
  logic [IDX_W-1:0]     first_port, next_port, hdr_port, cur_port;
  logic                 first_last, cur_last, hdr_last;

  logic                 c_valid, c_last;
  logic [DATA_W-1:0]    c_data;
  logic [KEEP_W-1:0]    c_keep;
  logic [DEST_W-1:0]    c_dest;
  logic [USER_W-1:0]    c_user;

  logic                 o_free, have_port, take_hdr, take_pay, load;
  logic [DATA_W-1:0]    hdr_word, d_data;
  logic [KEEP_W-1:0]    d_keep;
  logic                 d_last;

  // live mask until the first header of an event leaves, held mask after
  assign pick_mask = (state == ST_FIRST) ? en_mask : ev_mask;

  fseq_port_pick #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_pick (
    .mask       (pick_mask),
    .cur        (sel),
    .first      (first_port),
    .first_last (first_last),
    .nxt        (next_port),
    .cur_last   (cur_last)
  );

  assign hdr_port = (state == ST_FIRST) ? first_port : sel;
  assign hdr_last = (state == ST_FIRST) ? first_last : cur_last;
  assign cur_port = (state == ST_PAY) ? sel : hdr_port;

  always_comb begin
    c_valid = s_tvalid[cur_port];
    c_last  = s_tlast[cur_port];
    c_data  = s_tdata[cur_port*DATA_W +: DATA_W];
    c_keep  = s_tkeep[cur_port*KEEP_W +: KEEP_W];
    c_dest  = s_tdest[cur_port*DEST_W +: DEST_W];
    c_user  = s_tuser[cur_port*USER_W +: USER_W];
  end

  fseq_hdr_build #(.DATA_W(DATA_W), .DEST_W(DEST_W), .USER_W(USER_W), .IDX_W(IDX_W)) u_hdr (
    .dest      (c_dest),
    .user      (c_user),
    .port      (hdr_port),
    .evt       (evt_cnt),
    .last_flag (hdr_last),
    .hdr       (hdr_word)
  );

  assign have_port = (state != ST_FIRST) || (en_mask != '0);
  assign take_hdr  = (state != ST_PAY) && have_port && c_valid && o_free;
  assign take_pay  = (state == ST_PAY) && c_valid && o_free;
  assign load      = take_hdr || take_pay;
  assign d_data    = take_pay ? c_data : hdr_word;
  assign d_keep    = take_pay ? c_keep : '1;
  assign d_last    = take_pay && c_last;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_rdy
    assign s_tready[g] = (state == ST_PAY) && (sel == IDX_W'(g)) && o_free;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_FIRST;
      sel     <= '0;
      ev_mask <= '0;
      evt_cnt <= '0;
    end else begin
      case (state)
        ST_FIRST: if (take_hdr) begin
          ev_mask <= en_mask;
          sel     <= first_port;
          state   <= ST_PAY;
        end
        ST_HDR: if (take_hdr) state <= ST_PAY;
        ST_PAY: if (take_pay && c_last) begin
          if (cur_last) begin
            evt_cnt <= evt_cnt + 1'b1;
            state   <= ST_FIRST;
          end else begin
            sel   <= next_port;
            state <= ST_HDR;
          end
        end
        default: state <= ST_FIRST;
      endcase
    end
  end

  fseq_out_reg #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .d_data   (d_data),
    .d_keep   (d_keep),
    .d_last   (d_last),
    .free     (o_free),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tdata  (m_tdata),
    .m_tkeep  (m_tkeep),
    .m_tlast  (m_tlast)
  );

  assign m_tdest = '0;
  assign m_tuser = '0;

  // R4: at most one source is offered ready at a time
  assert_one_ready_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(s_tready));

  // R3: a port outside the held mask never sees ready
  assert_ready_enabled_R3: assert property (@(posedge clk) disable iff (rst)
    (|s_tready) |-> ((s_tready & ~ev_mask) == '0));

  // R7: the event count moves by exactly one step, with wrap
  assert_evt_step_R7: assert property (@(posedge clk) disable iff (rst)
    (evt_cnt != $past(evt_cnt)) |-> (evt_cnt == $past(evt_cnt) + 8'd1));

  // R7: the count moves only as an end-of-frame beat enters the output
  assert_evt_at_end_R7: assert property (@(posedge clk) disable iff (rst)
    (evt_cnt != $past(evt_cnt)) |-> (m_tvalid && m_tlast));
endmodule

// File: tb/tb_fseq_merge.sv
module tb_fseq_merge;
  localparam int CLK_PERIOD = 10;
  localparam int NP   = 3;
  localparam int DW   = 64;
  localparam int KW   = DW / 8;
  localparam int DSTW = 4;
  localparam int USRW = 3;
  localparam int SRCW = DSTW + USRW + 1 + KW + DW;
  localparam int EXPW = 1 + KW + DW;
  localparam int DEPTH = 64;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [NP-1:0]        en_mask = '0;
  logic [NP-1:0]        s_tvalid = '0;
  logic [NP-1:0]        s_tready;
  logic [NP*DW-1:0]     s_tdata = '0;
  logic [NP*KW-1:0]     s_tkeep = '0;
  logic [NP-1:0]        s_tlast = '0;
  logic [NP*DSTW-1:0]   s_tdest = '0;
  logic [NP*USRW-1:0]   s_tuser = '0;
  logic                 m_tvalid;
  logic                 m_tready = 1'b1;
  logic [DW-1:0]        m_tdata;
  logic [KW-1:0]        m_tkeep;
  logic                 m_tlast;
  logic [DSTW-1:0]      m_tdest;
  logic [USRW-1:0]      m_tuser;

  fseq_merge #(.NUM_PORTS(NP), .DATA_W(DW), .KEEP_W(KW), .DEST_W(DSTW), .USER_W(USRW)) dut (
    .clk(clk), .rst(rst), .en_mask(en_mask),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tkeep(s_tkeep),
    .s_tlast(s_tlast), .s_tdest(s_tdest), .s_tuser(s_tuser),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tkeep(m_tkeep),
    .m_tlast(m_tlast), .m_tdest(m_tdest), .m_tuser(m_tuser)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int n_out    = 0;
  int cyc      = 0;
  bit done     = 1'b0;
  bit bp_on    = 1'b0;
  logic [NP-1:0] gate = '1;
  logic [7:0]    ev_exp = '0;

  logic [SRCW-1:0] src_mem [NP][DEPTH];
  int              wr [NP];
  int              rd [NP];
  logic [EXPW-1:0] exp_q [$];
  string           tag_q [$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // push one event: source frames for enabled ports and the expected beats
  task automatic run_event(input logic [NP-1:0] mk, input int len0, input int len1, input int len2);
    int lens [NP];
    int hi;
    lens[0] = len0; lens[1] = len1; lens[2] = len2;
    hi = 0;
    for (int p = 0; p < NP; p++) if (mk[p]) hi = p;
    for (int p = 0; p < NP; p++) begin
      if (mk[p]) begin
        logic [DSTW-1:0] dst;
        logic [USRW-1:0] usr;
        logic [DW-1:0]   hdr;
        while ((wr[p] - rd[p]) >= DEPTH - 8) @(negedge clk);
        dst = DSTW'(p * 3 + int'(ev_exp) + 1);
        usr = USRW'(int'(ev_exp) + p + 2);
        hdr = '0;
        hdr[DSTW-1:0]   = dst;
        hdr[8 +: USRW]  = usr;
        hdr[23:16]      = 8'(p);
        hdr[31:24]      = ev_exp;
        hdr[32]         = (p == hi);
        exp_q.push_back({1'b0, {KW{1'b1}}, hdr});
        tag_q.push_back("R2/R3/R7/R8 header");
        for (int b = 0; b < lens[p]; b++) begin
          logic            lst;
          logic [KW-1:0]   kp;
          logic [DW-1:0]   dat;
          logic [DSTW-1:0] bd;
          logic [USRW-1:0] bu;
          lst = (b == lens[p] - 1);
          kp  = lst ? KW'(8'h3F >> (b % 3)) : {KW{1'b1}};
          dat = {ev_exp, 8'(p), 16'hA5C3, 32'(b * 7 + 1)};
          bd  = (b == 0) ? dst : ~dst;
          bu  = (b == 0) ? usr : ~usr;
          src_mem[p][wr[p] % DEPTH] = {bd, bu, lst, kp, dat};
          wr[p]++;
          exp_q.push_back({lst, kp, dat});
          tag_q.push_back("R5/R6 payload");
        end
      end
    end
    ev_exp = ev_exp + 8'd1;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // driver and monitor: drive after falling edge, settle, predict next edge
  initial begin
    logic            prev_stall;
    logic [EXPW-1:0] prev_beat;
    prev_stall = 1'b0;
    prev_beat  = '0;
    for (int p = 0; p < NP; p++) begin wr[p] = 0; rd[p] = 0; end
    forever begin
      @(negedge clk);
      cyc++;
      m_tready = bp_on ? ((cyc % 3) != 0) : 1'b1;
      for (int p = 0; p < NP; p++) begin
        if (gate[p] && (wr[p] != rd[p])) begin
          logic [SRCW-1:0] e;
          e = src_mem[p][rd[p] % DEPTH];
          s_tvalid[p]               = 1'b1;
          s_tdata[p*DW +: DW]       = e[DW-1:0];
          s_tkeep[p*KW +: KW]       = e[DW +: KW];
          s_tlast[p]                = e[DW+KW];
          s_tuser[p*USRW +: USRW]   = e[DW+KW+1 +: USRW];
          s_tdest[p*DSTW +: DSTW]   = e[DW+KW+1+USRW +: DSTW];
        end else begin
          s_tvalid[p] = 1'b0;
          s_tlast[p]  = 1'b0;
        end
      end
      #1;
      if (!rst) begin
        if (prev_stall)
          check(m_tvalid && ({m_tlast, m_tkeep, m_tdata} == prev_beat), "R9", "stalled beat held",
                {m_tvalid, m_tlast, m_tkeep, m_tdata}, {1'b1, prev_beat});
        prev_stall = m_tvalid && !m_tready;
        prev_beat  = {m_tlast, m_tkeep, m_tdata};
        if (m_tvalid && m_tready) begin
          n_out++;
          check((m_tdest == '0) && (m_tuser == '0), "R5", "sideband outputs zero",
                {m_tdest, m_tuser}, '0);
          if (exp_q.size() == 0) begin
            check(1'b0, "R6", "unexpected extra beat", {m_tlast, m_tkeep, m_tdata}, '0);
          end else begin
            logic [EXPW-1:0] ex;
            string           tg;
            ex = exp_q.pop_front();
            tg = tag_q.pop_front();
            check({m_tlast, m_tkeep, m_tdata} == ex, tg, "output beat",
                  {m_tlast, m_tkeep, m_tdata}, ex);
          end
        end
        for (int p = 0; p < NP; p++)
          if (s_tvalid[p] && s_tready[p]) rd[p]++;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    #2;
    check(!m_tvalid && (s_tready == '0), "R1", "idle outputs in reset",
          {m_tvalid, s_tready}, '0);
    @(negedge clk);
    rst = 1'b0;
    #2;
    check(!m_tvalid && (s_tready == '0), "R1", "idle outputs after reset",
          {m_tvalid, s_tready}, '0);

    // all ports, mixed lengths; first header carries count 0 (R1)
    en_mask = 3'b111;
    run_event(3'b111, 2, 1, 3);
    run_event(3'b111, 1, 4, 1);
    drain();

    // disabled middle port skipped (R3, R8)
    en_mask = 3'b101;
    run_event(3'b101, 3, 0, 2);
    run_event(3'b101, 1, 0, 1);
    drain();

    // selected port not yet valid while another is ready (R4)
    en_mask = 3'b011;
    gate = 3'b110;
    run_event(3'b011, 2, 2, 0);
    repeat (10) @(negedge clk);
    #2;
    base = n_out;
    check(s_tvalid[1] && (s_tready == '0), "R4", "ready port not served out of turn",
          {s_tvalid, s_tready}, {3'b010, 3'b000});
    repeat (6) @(negedge clk);
    #2;
    check(n_out == base, "R4", "no output while waiting", n_out, base);
    gate = 3'b111;
    drain();

    // backpressure on the output (R9)
    bp_on = 1'b1;
    en_mask = 3'b111;
    run_event(3'b111, 3, 2, 4);
    run_event(3'b111, 1, 1, 1);
    drain();
    bp_on = 1'b0;

    // mask change mid-event only affects the next event (R10)
    en_mask = 3'b011;
    gate = 3'b101;
    run_event(3'b011, 4, 2, 0);
    while (exp_q.size() > 6) @(negedge clk);
    en_mask = 3'b110;
    run_event(3'b110, 0, 3, 2);
    gate = 3'b111;
    drain();

    // zero mask: nothing moves (R10)
    en_mask = 3'b000;
    run_event(3'b001, 2, 0, 0);
    base = n_out;
    repeat (15) @(negedge clk);
    #2;
    check((n_out == base) && (s_tready == '0), "R10", "zero mask holds everything",
          {n_out[7:0], s_tready}, {base[7:0], 3'b000});
    en_mask = 3'b001;
    drain();

    // long run of single-port events to wrap the counter (R7)
    en_mask = 3'b100;
    for (int k = 0; k < 260; k++) run_event(3'b100, 0, 0, 1);
    drain();

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R6", "all expected beats seen", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule